// File: doc/BRIEF.md
# Tape Byte Buffer Handshake

This block moves one byte at a time between a host I/O port and the record stream of a tape controller while a read or a write command runs. A single 8-bit data register sits between the two sides. A busy flag paces the exchange, and its sense follows the direction. On a read, busy high means the host has taken the current byte and the register is free. On a write, busy high means the register holds a byte the tape side has not yet taken.

A command decoder starts a transfer with a one-cycle `start` pulse that carries the direction and, for reads, the record length. The first service happens one record latency after the start. Later services come every byte latency. A read runs until the whole record has been delivered. A write runs until a service finds the register empty, and then the accumulated record is committed to the framer. A host that falls behind is reported on `err`. A host that writes data after a write record has closed is also reported on `err`. Each byte service pulses `irq`.

Top module: `tape_byte_port`

## Requirements
- R1: After reset, `busy` is 1 and `err`, `irq`, `xfer` and `rec_end` are 0.
- R2: A `start` pulse while `xfer` is 0 sets `xfer` and clears `err`. It sets `busy` to 1 when `start_wr` is 0 (read) and to 0 when `start_wr` is 1 (write). A `start` pulse while `xfer` is 1 has no effect.
- R3: The first byte service happens REC_LAT cycles after the start edge. Each later service happens BYTE_LAT cycles after the previous one.
- R4: A read service with bytes remaining loads `src_data` into the data register, pulses `src_take`, clears `busy` and pulses `irq` for one cycle. `host_rdata` always shows the data register.
- R5: A `host_rd` or `host_wr` strobe sets `busy` only while `xfer` is 1. `host_wr` loads `host_wdata` into the data register in any state.
- R6: A read service that finds `busy` clear while bytes remain sets `err` (read overrun).
- R7: A read delivers exactly `start_len` bytes. At the next service `busy` clears, and `xfer` falls REC_LAT cycles later.
- R8: A write service that finds `busy` set pulses `irq` and clears `busy`. Within the limit of R10 it also emits the data register on `snk_data` with a one-cycle `snk_valid`.
- R9: A write service that finds `busy` clear ends the record. It pulses `rec_end` with the stored byte count on `rec_count`, but only when that count is non-zero. A record of zero bytes produces no `rec_end`.
- R10: Bytes past MAX_BYTES in one write record are dropped. They still clear `busy` and pulse `irq`, but produce no `snk_valid`, and `rec_count` stops at MAX_BYTES.
- R11: A `host_wr` after a write record has ended, while `xfer` is still 1, sets `err` (write overrun).
- R12: Once set, `err` stays set until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| start_wr | input | 1 | Direction with start: 1 write, 0 read |
| start_len | input | LEN_W | Read record length in bytes |
| host_rd | input | 1 | Host read strobe of the data register |
| host_wr | input | 1 | Host write strobe of the data register |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Data register contents |
| src_data | input | 8 | Current record byte from the framer (read) |
| src_take | output | 1 | Current source byte consumed |
| snk_valid | output | 1 | Byte delivered to the framer (write) |
| snk_data | output | 8 | Delivered byte |
| rec_end | output | 1 | Write record complete, commit it |
| rec_count | output | LEN_W | Byte count of the committed record |
| busy | output | 1 | Direction-dependent handshake flag |
| err | output | 1 | Overrun error |
| irq | output | 1 | Byte service interrupt pulse |
| xfer | output | 1 | Transfer in progress |

## Verification
A wrong timer shows up at once as an `irq` that arrives earlier or later than the REC_LAT or BYTE_LAT spacing. A busy flag with the wrong sense shows up at the next service, either as a spurious `err` or as a missing `err` when the host skips a byte. A byte counter that is off by one shows up at the end of the record, as one byte too many or too few taken from the source, or as a wrong `rec_count`. Both ends of the count are exercised: the record of zero bytes and the record that overruns the MAX_BYTES limit.

// File: rtl/tape_byte_port.sv
module tape_byte_port #(
  parameter int REC_LAT   = 1000,
  parameter int BYTE_LAT  = 10,
  parameter int MAX_BYTES = 4096,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_wr,
  input  logic [LEN_W-1:0] start_len,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic [7:0]       src_data,
  output logic             src_take,
  output logic             snk_valid,
  output logic [7:0]       snk_data,
  output logic             rec_end,
  output logic [LEN_W-1:0] rec_count,
  output logic             busy,
  output logic             err,
  output logic             irq,
  output logic             xfer
);
  localparam int LAT_MAX = (REC_LAT > BYTE_LAT) ? REC_LAT : BYTE_LAT;
  localparam int TW = $clog2(LAT_MAX + 1);
  localparam logic [TW-1:0] REC_LOAD  = TW'(REC_LAT - 1);
  localparam logic [TW-1:0] BYTE_LOAD = TW'(BYTE_LAT - 1);
  localparam logic [LEN_W-1:0] MAX_CNT = LEN_W'(MAX_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_BYTE, S_STOP} st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic             wr_dir;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt;
  logic [7:0]       dreg;

  wire tick     = (st == S_WAIT || st == S_BYTE) && (tmr == '0);
  wire rd_load  = tick && !wr_dir && (cnt < len_q);
  wire wr_take  = tick && wr_dir && busy;
  wire rec_done = tick && !rd_load && !wr_take;
  wire host_hit = xfer && (host_rd || host_wr);

  assign xfer       = (st != S_IDLE);
  assign src_take   = rd_load;
  assign host_rdata = dreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      wr_dir    <= 1'b0;
      len_q     <= '0;
      cnt       <= '0;
      dreg      <= '0;
      busy      <= 1'b1;
      err       <= 1'b0;
      irq       <= 1'b0;
      snk_valid <= 1'b0;
      snk_data  <= '0;
      rec_end   <= 1'b0;
      rec_count <= '0;
    end else begin
      irq       <= 1'b0;
      snk_valid <= 1'b0;
      rec_end   <= 1'b0;
      if (tmr != '0) tmr <= tmr - 1'b1;
      if (start && st == S_IDLE) begin
        st     <= S_WAIT;
        tmr    <= REC_LOAD;
        wr_dir <= start_wr;
        len_q  <= start_len;
        cnt    <= '0;
        busy   <= !start_wr;
        err    <= 1'b0;
      end else begin
        if (rd_load) begin
          if (!busy) err <= 1'b1;
          dreg <= src_data;
          cnt  <= cnt + 1'b1;
          busy <= 1'b0;
          irq  <= 1'b1;
          st   <= S_BYTE;
          tmr  <= BYTE_LOAD;
        end
        if (wr_take) begin
          if (cnt < MAX_CNT) begin
            snk_valid <= 1'b1;
            snk_data  <= dreg;
            cnt       <= cnt + 1'b1;
          end
          busy <= 1'b0;
          irq  <= 1'b1;
          st   <= S_BYTE;
          tmr  <= BYTE_LOAD;
        end
        if (rec_done) begin
          st   <= S_STOP;
          tmr  <= REC_LOAD;
          busy <= 1'b0;
          if (wr_dir && cnt != '0) begin
            rec_end   <= 1'b1;
            rec_count <= cnt;
          end
        end
        if (st == S_STOP && tmr == '0) st <= S_IDLE;
        if (host_hit) busy <= 1'b1;
        if (host_wr && wr_dir && st == S_STOP) err <= 1'b1;
      end
      if (host_wr && !(rd_load && !(start && st == S_IDLE))) dreg <= host_wdata;
    end
  end
endmodule

// File: rtl/tape_byte_port_chk.sv
module tape_byte_port_chk #(
  parameter int MAX_BYTES = 4096,
  parameter int LEN_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             host_rd,
  input logic             host_wr,
  input logic             busy,
  input logic             err,
  input logic             irq,
  input logic             xfer,
  input logic             src_take,
  input logic             snk_valid,
  input logic             rec_end,
  input logic [LEN_W-1:0] rec_count
);
  logic [LEN_W:0] nsnk;

  always_ff @(posedge clk) begin
    if (!rst_n) nsnk <= '0;
    else if (start && !xfer) nsnk <= '0;
    else if (snk_valid) nsnk <= nsnk + 1'b1;
  end

  // R5
  busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(host_rd || host_wr || start));

  // R4
  irq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy || $past(host_rd || host_wr)));

  // R8
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_take && snk_valid));

  // R9
  zero_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_end |-> (rec_count != '0));

  // R10
  drop_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nsnk <= (LEN_W+1)'(MAX_BYTES)) && (!rec_end || rec_count <= LEN_W'(MAX_BYTES)));

  // R12
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(start));
endmodule

bind tape_byte_port tape_byte_port_chk #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .host_rd(host_rd), .host_wr(host_wr),
  .busy(busy), .err(err), .irq(irq), .xfer(xfer), .src_take(src_take),
  .snk_valid(snk_valid), .rec_end(rec_end), .rec_count(rec_count)
);

// File: tb/test_tape_byte_port.sv
`timescale 1ns/1ps
module test_tape_byte_port;
  localparam int REC = 12;
  localparam int BYT = 6;
  localparam int MAXB = 4;
  localparam int LW = 16;
  localparam int NV = 7;
  // {dir[23], n[22:16], skip mask[15:8], expected err[0]}
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 7'd3, 8'h00, 8'h00},
    {1'b0, 7'd4, 8'h02, 8'h01},
    {1'b0, 7'd2, 8'h02, 8'h00},
    {1'b0, 7'd1, 8'h00, 8'h00},
    {1'b1, 7'd3, 8'h00, 8'h00},
    {1'b1, 7'd0, 8'h00, 8'h00},
    {1'b1, 7'd6, 8'h00, 8'h00}
  };

  logic clk = 0, rst_n = 0;
  logic start = 0, start_wr = 0;
  logic [LW-1:0] start_len = 0;
  logic host_rd = 0, host_wr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata, src_data, snk_data;
  logic src_take, snk_valid, rec_end, busy, err, irq, xfer;
  logic [LW-1:0] rec_count;

  int checks = 0, errors = 0;
  int src_idx = 0, nsnk = 0, nend = 0, nirq = 0;
  logic [7:0] got [64];
  logic [LW-1:0] last_cnt = 0;

  always #2.5 clk = ~clk;

  tape_byte_port #(.REC_LAT(REC), .BYTE_LAT(BYT), .MAX_BYTES(MAXB), .LEN_W(LW)) i_tape_byte_port (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr), .start_len(start_len),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .src_data(src_data), .src_take(src_take), .snk_valid(snk_valid), .snk_data(snk_data),
    .rec_end(rec_end), .rec_count(rec_count), .busy(busy), .err(err), .irq(irq), .xfer(xfer)
  );

  assign src_data = 8'(src_idx) ^ 8'h5A;

  always @(posedge clk) if (src_take) src_idx <= src_idx + 1;

  always @(negedge clk) begin
    if (snk_valid) begin got[nsnk % 64] <= snk_data; nsnk <= nsnk + 1; end
    if (rec_end) begin nend <= nend + 1; last_cnt <= rec_count; end
    if (irq) nirq <= nirq + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 200) begin @(negedge clk); n++; end
    if (!irq) check(0, req, 0, 1);
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (xfer && n < 400) begin @(negedge clk); n++; end
    if (xfer) check(0, req, 1, 0);
  endtask

  task automatic do_start(input logic wr, input int len);
    start = 1; start_wr = wr; start_len = LW'(len);
    @(negedge clk);
    start = 0;
  endtask

  task automatic pulse_rd();
    host_rd = 1; @(negedge clk); host_rd = 0;
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    host_wr = 1; host_wdata = d; @(negedge clk); host_wr = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 1 && err === 0 && irq === 0 && xfer === 0 && rec_end === 0, "R1", busy, 1);
    rst_n = 1;
    @(negedge clk);

    // R3 timing, R2 ignored start, R4 load
    begin
      int n = 0;
      int idx0 = src_idx;
      do_start(0, 2);
      n = 1;
      check(busy === 1 && xfer === 1, "R2 read start busy", busy, 1);
      while (!irq && n < 200) begin @(negedge clk); n++; end
      check(n == REC + 1, "R3 first service", n, REC + 1);
      check(host_rdata == (8'(idx0) ^ 8'h5A), "R4 first byte", host_rdata, 8'(idx0) ^ 8'h5A);
      check(busy === 0, "R4 busy clear", busy, 0);
      start = 1; start_wr = 0; @(negedge clk); start = 0;
      check(busy === 0 && xfer === 1, "R2 start ignored", busy, 0);
      pulse_rd();
      check(busy === 1, "R5 host read sets busy", busy, 1);
      n = 2;
      while (!irq && n < 200) begin @(negedge clk); n++; end
      check(n == BYT, "R3 byte spacing", n, BYT);
      pulse_rd();
      wait_idle("R7 idle");
      check(err === 0, "R6 no overrun", err, 0);
    end

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      logic dir;
      int n, skip, experr, idx0, s0, e0, i0, expn;
      dir = VEC[v][23]; n = int'(VEC[v][22:16]); skip = int'(VEC[v][15:8]); experr = int'(VEC[v][0]);
      idx0 = src_idx; s0 = nsnk; e0 = nend; i0 = nirq;
      do_start(dir, dir ? 0 : n);
      check(busy === !dir && err === 0, "R2 start state", busy, !dir);
      if (!dir) begin
        for (int i = 0; i < n; i++) begin
          wait_irq("R4 read irq");
          check(host_rdata == (8'(idx0 + i) ^ 8'h5A), "R4 read data", host_rdata, 8'(idx0 + i) ^ 8'h5A);
          if (!skip[i]) pulse_rd(); else @(negedge clk);
        end
        wait_idle("R7 read end");
        check(src_idx - idx0 == n, "R7 bytes taken", src_idx - idx0, n);
        check(nirq - i0 == n, "R7 irq count", nirq - i0, n);
        check(busy === 0, "R7 busy clear at end", busy, 0);
        check(err === experr[0], "R6 overrun flag", err, experr);
      end else begin
        expn = (n < MAXB) ? n : MAXB;
        for (int i = 0; i < n; i++) begin
          if (i > 0) wait_irq("R8 write irq");
          pulse_wr(8'hA0 + 8'(i));
        end
        if (n > 0) wait_irq("R8 last irq");
        wait_idle("R9 write end");
        check(nirq - i0 == n, "R10 irq per write", nirq - i0, n);
        check(nsnk - s0 == expn, "R10 stored bytes", nsnk - s0, expn);
        for (int i = 0; i < expn; i++)
          check(got[(s0 + i) % 64] == 8'hA0 + 8'(i), "R8 write data", got[(s0 + i) % 64], 8'hA0 + 8'(i));
        check(nend - e0 == (n > 0 ? 1 : 0), "R9 record commit", nend - e0, n > 0);
        if (n > 0) check(last_cnt == LW'(expn), "R9 record count", last_cnt, expn);
        check(err === 0, "R8 no error", err, 0);
      end
    end

    // R11 write overrun in stop stage, R12 hold
    begin
      int n = 0;
      do_start(1, 0);
      pulse_wr(8'h11);
      wait_irq("R11 irq");
      while (!rec_end && n < 200) begin @(negedge clk); n++; end
      check(rec_end === 1, "R9 rec_end seen", rec_end, 1);
      check(err === 0, "R11 before", err, 0);
      pulse_wr(8'h22);
      check(err === 1, "R11 write overrun", err, 1);
      wait_idle("R11 idle");
      repeat (3) @(negedge clk);
      check(err === 1, "R12 err held", err, 1);
      do_start(1, 0);
      check(err === 0, "R12 err cleared by start", err, 0);
      wait_idle("R9 zero record idle");
      check(busy === 0, "R9 busy clear", busy, 0);
      pulse_wr(8'h3C);
      check(busy === 0, "R5 strobe outside transfer", busy, 0);
      pulse_rd();
      check(busy === 0 && host_rdata == 8'h3C, "R5 data reg loaded idle", host_rdata, 8'h3C);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule